// File: doc/BRIEF.md
# Two-Wire Slave Memory Engine

This block is the protocol engine of a small byte-wide serial memory that answers on a two-wire I2C-style bus. It runs on a fast system clock and oversamples the bus clock and data lines. It passes each line through a synchronizer and a short glitch filter, then finds START and STOP conditions and clock edges. A control byte names the device with a fixed code and three strapped select inputs. The engine then either takes a word address and data bytes, or streams data bytes back to the master. The SDA output is an open-drain pull-down enable.

A 128-byte array sits behind an internal write port and a combinational read port. A single address pointer is shared by all operations. Write transfers roll over within a 16-byte page. Read transfers step through the whole array and wrap from the top address to zero. After a STOP that ends a write carrying data, a programmable busy window models the internal programming time. During that window the engine answers nothing, so a master can poll for completion.

Top module: `i2cm_slave`

## Requirements
- R1: A falling SDA while filtered SCL is high (START) restarts control-byte reception from any state, even mid-byte. A rising SDA while SCL is high (STOP) returns the engine to idle with SDA released.
- R2: Bytes are sent MSB first. A control byte is accepted only if bits 7:4 are 1010 and bits 3:1 equal chip_sel. Bit 0 then selects read (1) or write (0). Any other control byte gets no acknowledge, and the engine ignores the bus until the next START.
- R3: An acknowledge holds sda_pull high for the whole high phase of the ninth clock. sda_pull changes only while the filtered SCL is low.
- R4: A STOP that ends a write with at least one data byte starts a busy window of WR_CYCLES clocks. During that window no byte is acknowledged, the control byte included. After the window, control bytes are acknowledged again.
- R5: In a write transfer, the byte after the control byte loads the address pointer from its low 7 bits. Bit 7 is ignored.
- R6: Each data byte of a write is stored at the pointer. The low 4 pointer bits then increment modulo 16, and the upper 3 bits are held, so a long burst wraps inside its 16-byte page.
- R7: A read control byte with no preceding address returns the byte at the current pointer. Each byte sent advances the pointer by one.
- R8: A write control byte and an address, followed by a repeated START and a read control byte, return the byte at that address.
- R9: A master acknowledge after a read byte makes the engine send the next byte. The read pointer wraps from address 0x7F to 0x00 and is not confined to a page.
- R10: After a master no-acknowledge, and whenever the engine is idle, sda_pull stays low until a new START.
- R11: Pulses on SCL or SDA shorter than FILT_HOLD system clocks have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired-AND level) |
| chip_sel | input | 3 | Strapped select value compared with control bits 3:1 |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Writes are tried as a single byte and as a four-byte burst that crosses the page end. The burst separates the page-limited write increment from the full-array read increment. Reads are tried as current-address reads, random reads and sequential reads across 0x7F, which separates the shared pointer from a fresh address load. Control bytes with a wrong select value, a wrong device code and a busy device are each refused. A STOP or a repeated START in the middle of a byte shows recovery. An address byte with sub-filter pulses on both lines must still select the intended location.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} eng_state_t;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} rx_kind_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BYTE_W = 8;

  // Control byte matches device code and strapped select value.
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
  endfunction

  // Write-side increment: only the low pw bits count.
  function automatic logic [15:0] page_next(input logic [15:0] a, input int pw);
    logic [15:0] m;
    m = (16'd1 << pw) - 16'd1;
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // Read-side increment: whole array, wraps at 2**aw.
  function automatic logic [15:0] seq_next(input logic [15:0] a, input int aw);
    return (a + 16'd1) & ((16'd1 << aw) - 16'd1);
  endfunction

endpackage

// File: rtl/i2cm_deglitch.sv
module i2cm_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_HOLD   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt    <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (synced == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_HOLD - 1)) begin
        dout <= synced;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_events.sv
module i2cm_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign ev_start = scl & scl_q & sda_q & ~sda;
  assign ev_stop  = scl & scl_q & ~sda_q & sda;
  assign ev_rise  = scl & ~scl_q;
  assign ev_fall  = ~scl & scl_q;
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_HOLD   = 3,
  parameter int WR_CYCLES   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  output logic       sda_pull
);
  localparam int BW = $clog2(WR_CYCLES + 1);

  // filtered lines: index 0 = SCL, index 1 = SDA
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cm_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_HOLD(FILT_HOLD)) u_dg (
      .clk(clk), .rst_n(rst_n), .din(raw_lines[g]), .dout(filt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  logic ev_start, ev_stop, ev_rise, ev_fall;
  i2cm_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  eng_state_t         st;
  rx_kind_t           kind;
  logic [3:0]         bitcnt;
  logic [6:0]         shreg;
  logic [7:0]         txsh;
  logic [ADDR_W-1:0]  ptr;
  logic               rd_mode, ack_pend, m_ack, wrote;
  logic [BW-1:0]      busy_cnt;

  logic [7:0]         rx_byte, mem_rdata;
  logic               busy, ctrl_ok, mem_we;
  logic [ADDR_W-1:0]  ptr_page, ptr_seq;

  // named internal events for the checker
  logic in_idle, ctrl_armed;
  assign in_idle    = (st == ST_IDLE);
  assign ctrl_armed = (st == ST_RX) && (kind == K_CTRL) && (bitcnt == 4'd0);

  assign rx_byte  = {shreg, sda_f};
  assign busy     = (busy_cnt != '0);
  assign ctrl_ok  = ctrl_hit(rx_byte, chip_sel) && !busy;
  assign ptr_page = ADDR_W'(page_next(16'(ptr), PAGE_W));
  assign ptr_seq  = ADDR_W'(seq_next(16'(ptr), ADDR_W));
  assign mem_we   = (st == ST_RX) && (kind == K_DATA) && ev_rise && (bitcnt == 4'd7);

  i2cm_store #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(rx_byte),
    .raddr(ptr), .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= K_CTRL;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      rd_mode  <= 1'b0;
      ack_pend <= 1'b0;
      m_ack    <= 1'b0;
      wrote    <= 1'b0;
      sda_pull <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (ev_stop) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
        bitcnt   <= '0;
        ack_pend <= 1'b0;
        wrote    <= 1'b0;
        if (wrote) busy_cnt <= BW'(WR_CYCLES);
      end else if (ev_start) begin
        st       <= ST_RX;
        kind     <= K_CTRL;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        ack_pend <= 1'b0;
        wrote    <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (ev_rise) begin
              if (bitcnt < 4'd8) begin
                shreg  <= rx_byte[6:0];
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 4'd7) begin
                  case (kind)
                    K_CTRL: begin
                      if (ctrl_ok) begin
                        ack_pend <= 1'b1;
                        rd_mode  <= rx_byte[0];
                      end else begin
                        st <= ST_IDLE;
                      end
                    end
                    K_ADDR: begin
                      ptr      <= rx_byte[ADDR_W-1:0];
                      ack_pend <= 1'b1;
                    end
                    default: begin
                      ptr      <= ptr_page;
                      wrote    <= 1'b1;
                      ack_pend <= 1'b1;
                    end
                  endcase
                end
              end else begin
                bitcnt <= 4'd9;
              end
            end else if (ev_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= ack_pend;
              end else if (bitcnt == 4'd9) begin
                ack_pend <= 1'b0;
                bitcnt   <= '0;
                if (kind == K_CTRL && rd_mode) begin
                  st       <= ST_TX;
                  txsh     <= mem_rdata;
                  sda_pull <= ~mem_rdata[7];
                  ptr      <= ptr_seq;
                end else begin
                  sda_pull <= 1'b0;
                  kind     <= (kind == K_CTRL) ? K_ADDR : K_DATA;
                end
              end
            end
          end
          ST_TX: begin
            if (ev_rise) begin
              if (bitcnt == 4'd8) m_ack <= ~sda_f;
              bitcnt <= bitcnt + 1'b1;
            end else if (ev_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_pull <= ~txsh[6];
              end else if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (m_ack) begin
                  txsh     <= mem_rdata;
                  sda_pull <= ~mem_rdata[7];
                  ptr      <= ptr_seq;
                end else begin
                  st       <= ST_IDLE;
                  sda_pull <= 1'b0;
                end
              end
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_pull,
  input logic ev_start,
  input logic ev_stop,
  input logic busy,
  input logic in_idle,
  input logic ctrl_armed
);
  // R1: STOP leaves the engine idle and SDA released
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (in_idle && !sda_pull));

  // R1: START re-arms control byte reception
  a_r1_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> ctrl_armed);

  // R3: SDA drive only moves while filtered SCL was low
  a_r3_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_f));

  // R4: nothing is acknowledged during the busy window
  a_r4_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  // R10: an idle engine never pulls SDA
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull);
endmodule

bind i2cm_slave i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull(sda_pull),
  .ev_start(ev_start), .ev_stop(ev_stop), .busy(busy),
  .in_idle(in_idle), .ctrl_armed(ctrl_armed)
);

// File: tb/i2cm_slave_test.sv
module i2cm_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;
  localparam int WR         = 3000;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = 8'hAA;
  localparam logic [7:0] CR = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  wire  sda_bus = m_sda & ~sda_pull;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_slave #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .chip_sel(SEL), .sda_pull(sda_pull)
  );

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic [7:0] obs_val;
  event obs_ev;

  // scoreboard monitor
  initial begin
    forever begin
      exp_t e;
      @(obs_ev);
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL none: unexpected result actual=%02h expected=nothing", obs_val);
      end else begin
        e = exp_q.pop_front();
        if (obs_val !== e.val) begin
          fails++;
          $display("FAIL %s: actual=%02h expected=%02h", e.req, obs_val, e.val);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic c, input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  task automatic expect_v(input logic [7:0] v, input string r);
    exp_q.push_back('{v, r});
  endtask

  task automatic observe(input logic [7:0] v);
    obs_val = v;
    -> obs_ev;
    wq(1);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic write_bit(input logic b, input logic gscl, input logic gsda);
    m_sda = b;
    wq(Q/2);
    if (gscl) begin m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(Q/2 - 2); end
    else wq(Q/2);
    m_scl = 1'b1;
    wq(Q);
    if (gsda) begin m_sda = ~b; wq(2); m_sda = b; wq(Q - 2); end
    else wq(Q);
    m_scl = 1'b0;
    wq(Q);
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_g(input logic [7:0] v, input logic [7:0] gscl, input logic [7:0] gsda,
                        input logic exp_ack, input string r);
    logic b;
    expect_v({7'd0, exp_ack}, r);
    for (int i = 7; i >= 0; i--) write_bit(v[i], gscl[i], gsda[i]);
    read_bit(b);
    observe({7'd0, ~b});
  endtask

  task automatic send(input logic [7:0] v, input logic exp_ack, input string r);
    send_g(v, 8'h00, 8'h00, exp_ack, r);
  endtask

  task automatic recv(input logic [7:0] exp, input logic more, input string r);
    logic [7:0] v;
    logic b;
    expect_v(exp, r);
    for (int i = 7; i >= 0; i--) begin read_bit(b); v[i] = b; end
    write_bit(~more, 1'b0, 1'b0);
    observe(v);
  endtask

  task automatic wr_bytes(input logic [7:0] a, input logic [7:0] d0, input int n, input string r);
    bus_start();
    send(CW, 1'b1, r);
    send(a, 1'b1, r);
    for (int i = 0; i < n; i++) send(d0 + 8'(i), 1'b1, r);
    bus_stop();
    wq(WR + 100);
  endtask

  task automatic rand_rd_start(input logic [7:0] a, input string r);
    bus_start();
    send(CW, 1'b1, r);
    send(a, 1'b1, r);
    bus_start();
    send(CR, 1'b1, r);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wq(10);
    rst_n = 1'b1;
    wq(10);
    check(sda_pull == 1'b0, "R10 reset released", {7'd0, sda_pull}, 8'h00);

    // R5 R6: single byte write at 0x10
    bus_start();
    send(CW, 1'b1, "R2 write ctrl ack");
    send(8'h10, 1'b1, "R5 addr ack");
    send(8'h5A, 1'b1, "R6 data ack");
    bus_stop();

    // R4: poll during busy, then after
    bus_start();
    send(CW, 1'b0, "R4 busy nack");
    check(sda_pull == 1'b0, "R4 busy released", {7'd0, sda_pull}, 8'h00);
    bus_stop();
    wq(WR + 100);
    bus_start();
    send(CW, 1'b1, "R4 ack after busy");
    bus_stop();

    // R8 random read
    rand_rd_start(8'h10, "R8 setup");
    recv(8'h5A, 1'b0, "R8 random read");
    check(sda_pull == 1'b0, "R10 released after nack", {7'd0, sda_pull}, 8'h00);
    wq(Q);
    check(sda_pull == 1'b0, "R10 still released", {7'd0, sda_pull}, 8'h00);
    bus_stop();

    // R7 current read at 0x11 (reset content)
    bus_start();
    send(CR, 1'b1, "R7 ctrl");
    recv(8'h00, 1'b0, "R7 current read 0x11");
    bus_stop();

    // R6 page burst 0x1E: A0 A1 then wrap to 0x10 A2, 0x11 A3
    wr_bytes(8'h1E, 8'hA0, 4, "R6 burst");
    rand_rd_start(8'h10, "R6 setup");
    recv(8'hA2, 1'b0, "R6 page wrap to 0x10");
    bus_stop();
    bus_start();
    send(CR, 1'b1, "R7 ctrl");
    recv(8'hA3, 1'b0, "R7 current read follows 0x10");
    bus_stop();

    // R9 sequential read runs past page end
    rand_rd_start(8'h1E, "R9 setup");
    recv(8'hA0, 1'b1, "R9 seq 0x1E");
    recv(8'hA1, 1'b1, "R9 seq 0x1F");
    recv(8'h00, 1'b0, "R9 seq 0x20");
    bus_stop();

    // R9 wrap 0x7F -> 0x00
    wr_bytes(8'h7F, 8'hC3, 1, "R9 wr 7F");
    wr_bytes(8'h00, 8'h3C, 1, "R9 wr 00");
    rand_rd_start(8'h7F, "R9 setup");
    recv(8'hC3, 1'b1, "R9 read 0x7F");
    recv(8'h3C, 1'b0, "R9 wrap to 0x00");
    bus_stop();

    // R2 refused control bytes
    bus_start();
    send(8'hA8, 1'b0, "R2 wrong select");
    bus_stop();
    bus_start();
    send(8'hBA, 1'b0, "R2 wrong code");
    bus_stop();

    // R5 address bit 7 ignored
    rand_rd_start(8'h90, "R5 setup");
    recv(8'hA2, 1'b0, "R5 addr 0x90 -> 0x10");
    bus_stop();

    // R1 STOP mid-byte, then recovery
    bus_start();
    send(CW, 1'b1, "R1 ctrl");
    write_bit(1'b0, 1'b0, 1'b0);
    write_bit(1'b1, 1'b0, 1'b0);
    write_bit(1'b1, 1'b0, 1'b0);
    bus_stop();
    check(sda_pull == 1'b0, "R1 stop releases", {7'd0, sda_pull}, 8'h00);
    bus_start();
    send(CW, 1'b1, "R1 recovers after stop");
    bus_stop();

    // R1 repeated START mid-byte
    bus_start();
    send(CW, 1'b1, "R1 ctrl");
    for (int i = 0; i < 4; i++) write_bit(1'b1, 1'b0, 1'b0);
    bus_start();
    send(CR, 1'b1, "R1 restart mid-byte");
    recv(8'hA3, 1'b0, "R1 pointer kept 0x11");
    bus_stop();

    // R11 sub-filter pulses on both lines in address 0x1E
    bus_start();
    send(CW, 1'b1, "R11 ctrl");
    send_g(8'h1E, 8'hFF, 8'hFF, 1'b1, "R11 addr ack");
    bus_start();
    send(CR, 1'b1, "R11 read ctrl");
    recv(8'hA0, 1'b0, "R11 glitch ignored");
    bus_stop();

    wq(10);
    check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule